// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-visible register set of a single-channel DMA engine that moves data between a peripheral and memory. A simple register bus selects one of four 32-bit words with a 2-bit select, and writes are qualified by a write enable. Word 0 is the control/status register. Word 1 is the current transfer address. Word 2 is the byte counter. Word 3 is the queued next-address slot, which is read-only.

The block keeps the writable control bits, such as direction, run, interrupt enable, count enable, fast mode, the terminal-count interrupt mask and next-address enable. It also keeps the sticky status flags that the datapath raises: terminal count, error pending, slave error and pack count. It drives the engine's run, direction, fast-mode and soft-reset outputs and the current address. It merges the flags and a peripheral interrupt line into one interrupt output.

Command bits behave in three ways. A flush command acts once and reads back as zero. The soft-reset bit holds the whole channel cleared until software writes it back to zero. The terminal-count mask silences only the counter's interrupt and leaves error and peripheral interrupts alone.

Top module: `dma_csr_regs`

## Requirements
- R1: Reading word 0 returns 0x9 in bits 31:28, zero in bits 19:16 and in bit 5, and zero in every bit not named in R2 to R9. After power-on reset, word 0 reads 0x9000_0000.
- R2: The read/write control bits are interrupt enable (bit 4), direction (bit 8, 1 = device to memory), run (bit 9), count enable (bit 13), fast mode (bit 22), terminal-count interrupt mask (bit 23) and next-address enable (bit 24). Each reads back as written. ena_o, dir_o and fast_o follow bits 9, 8 and 22. Writes to read-only and unused bits are ignored.
- R3: Soft reset (bit 7) stays set until software writes 0, and eng_rst_o follows it. While it is set, every other control bit, flag, the pack count, both addresses, both loaded flags and the counter are cleared and held, and writes to them are ignored. rst_ni clears everything, bit 7 included.
- R4: Writing 1 to flush (bit 5) clears the pack count (bits 3:2), error pending (bit 1) and terminal count (bit 14) at the next edge. This holds even when an error or a terminal-count event occurs in the same cycle.
- R5: The byte counter is CW bits wide at word 2. A cnt_dec_i pulse decrements it and increments the current address, but only when run and count enable are set and the count is nonzero. The step from 1 to 0 sets terminal count (bit 14). At zero the counter does not wrap.
- R6: Interrupt pending (bit 0) equals dev_irq_i OR (terminal count AND NOT mask bit 23). irq_o equals interrupt enable AND (bit 0 OR bit 1).
- R7: An err_i pulse sets error pending (bit 1) and slave error (bit 6). Flush does not clear slave error; only a reset clears it.
- R8: A pack_we_i pulse loads pack_cnt_i into bits 3:2. Bits 12:11 show byte_off_i and bit 25 shows active_i.
- R9: A write to word 1 while active_i is low loads the current address and sets bit 26. While active_i and next-address enable are both high, the write loads word 3 and sets bit 27. While active_i is high and next-address enable is low, the write is ignored. A nxt_take_i pulse with bit 27 set moves word 3 into the current address and clears bit 27.
- R10: Writes take effect at the clock edge that samples them, and read data is combinational from sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Word select: 0 control/status, 1 address, 2 count, 3 next address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected word |
| dev_irq_i | input | 1 | Peripheral interrupt request |
| err_i | input | 1 | Slave error event strobe |
| pack_we_i | input | 1 | Pack-count update strobe |
| pack_cnt_i | input | 2 | Bytes held in the pack register |
| byte_off_i | input | 2 | Current byte offset |
| active_i | input | 1 | Engine busy with a transfer |
| cnt_dec_i | input | 1 | One byte moved |
| nxt_take_i | input | 1 | Engine consumes the queued next address |
| irq_o | output | 1 | Interrupt request |
| eng_rst_o | output | 1 | Engine soft reset |
| ena_o | output | 1 | Engine run |
| dir_o | output | 1 | Transfer direction |
| fast_o | output | 1 | Fast mode |
| cur_addr_o | output | AW | Current transfer address |

## Verification
All 128 combinations of the seven control bits are written with the read-only and unused bits set. This shows whether any writable bit is stuck or cross-wired, and whether a read-only field accepts writes. The counter is loaded with every value from 1 to 15 and stepped down one pulse at a time. This shows whether terminal count fires exactly at zero rather than one step early or late, and whether the counter and address stop at zero. The interrupt logic is swept over all 32 combinations of enable, peripheral request, terminal count, mask and error pending. This separates the masked path from the unmasked ones. Directed cases cover flush arriving together with events, the address-slot choices, and the sticky soft reset.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int P_IP    = 0;
  localparam int P_EP    = 1;
  localparam int P_PACK  = 2;
  localparam int P_IE    = 4;
  localparam int P_FLUSH = 5;
  localparam int P_SERR  = 6;
  localparam int P_SRST  = 7;
  localparam int P_DIR   = 8;
  localparam int P_RUN   = 9;
  localparam int P_BOFF  = 11;
  localparam int P_CNTEN = 13;
  localparam int P_TC    = 14;
  localparam int P_FAST  = 22;
  localparam int P_TCMSK = 23;
  localparam int P_NXTEN = 24;
  localparam int P_ACT   = 25;
  localparam int P_CURV  = 26;
  localparam int P_NXTV  = 27;
  localparam int P_ID    = 28;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NXT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic nxt_en;
    logic tc_mask;
    logic fast;
    logic cnt_en;
    logic run;
    logic dir;
    logic ie;
  } ctl_t;
endpackage

// File: rtl/dma_ctl_bits.sv
module dma_ctl_bits
  import dma_csr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csr_wr_i,
  input  ctl_t wr_ctl_i,
  input  logic wr_srst_i,
  output ctl_t ctl_o,
  output logic srst_o
);
  ctl_t ctl_q;
  logic srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0;
      ctl_q  <= '0;
    end else begin
      if (csr_wr_i) srst_q <= wr_srst_i;
      // held clear while soft reset is (or is becoming) active
      if (srst_q || (csr_wr_i && wr_srst_i)) ctl_q <= '0;
      else if (csr_wr_i)                     ctl_q <= wr_ctl_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign srst_o = srst_q;

  assert_srst_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_wr_i |=> $stable(srst_q));
  assert_ctl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_q && !csr_wr_i) |=> (ctl_q == '0));
endmodule

// File: rtl/dma_stat_flags.sv
module dma_stat_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       flush_i,
  input  logic       tc_evt_i,
  input  logic       err_i,
  input  logic       pack_we_i,
  input  logic [1:0] pack_cnt_i,
  output logic       tc_o,
  output logic       ep_o,
  output logic       serr_o,
  output logic [1:0] pack_o
);
  logic       tc_q, ep_q, serr_q;
  logic [1:0] pack_q;
  logic       wipe;

  assign wipe = srst_i || flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q   <= 1'b0;
      ep_q   <= 1'b0;
      serr_q <= 1'b0;
      pack_q <= '0;
    end else begin
      // flush beats same-cycle events
      if (wipe)          tc_q <= 1'b0;
      else if (tc_evt_i) tc_q <= 1'b1;
      if (wipe)          ep_q <= 1'b0;
      else if (err_i)    ep_q <= 1'b1;
      if (srst_i)        serr_q <= 1'b0;
      else if (err_i)    serr_q <= 1'b1;
      if (wipe)          pack_q <= '0;
      else if (pack_we_i) pack_q <= pack_cnt_i;
    end
  end

  assign tc_o   = tc_q;
  assign ep_o   = ep_q;
  assign serr_o = serr_q;
  assign pack_o = pack_q;

  assert_flush_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!tc_q && !ep_q && (pack_q == 2'b00)));
  assert_tc_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_q) |-> $past(tc_evt_i));
  assert_serr_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serr_q && !srst_i) |=> serr_q);
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          addr_wr_i,
  input  logic          cnt_wr_i,
  input  logic [AW-1:0] addr_wd_i,
  input  logic [CW-1:0] cnt_wd_i,
  input  logic          active_i,
  input  logic          nxt_en_i,
  input  logic          run_i,
  input  logic          cnt_dec_i,
  input  logic          nxt_take_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] nxt_o,
  output logic [CW-1:0] cnt_o,
  output logic          cur_vld_o,
  output logic          nxt_vld_o,
  output logic          tc_evt_o
);
  logic [AW-1:0] cur_q, nxt_q;
  logic [CW-1:0] cnt_q;
  logic          cur_vld_q, nxt_vld_q;
  logic          dec_ok, take;

  assign dec_ok = cnt_dec_i && run_i && (cnt_q != '0);
  assign take   = nxt_take_i && nxt_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      nxt_q     <= '0;
      cnt_q     <= '0;
      cur_vld_q <= 1'b0;
      nxt_vld_q <= 1'b0;
    end else if (srst_i) begin
      cur_q     <= '0;
      nxt_q     <= '0;
      cnt_q     <= '0;
      cur_vld_q <= 1'b0;
      nxt_vld_q <= 1'b0;
    end else begin
      if (cnt_wr_i)    cnt_q <= cnt_wd_i;
      else if (dec_ok) cnt_q <= cnt_q - 1'b1;

      if (take) begin
        cur_q     <= nxt_q;
        cur_vld_q <= 1'b1;
        nxt_vld_q <= 1'b0;
      end else if (addr_wr_i && !active_i) begin
        cur_q     <= addr_wd_i;
        cur_vld_q <= 1'b1;
      end else if (addr_wr_i && nxt_en_i) begin
        nxt_q     <= addr_wd_i;
        nxt_vld_q <= 1'b1;
      end else if (dec_ok) begin
        cur_q <= cur_q + 1'b1;
      end
    end
  end

  assign tc_evt_o  = dec_ok && !cnt_wr_i && (cnt_q == CW'(1));
  assign cur_o     = cur_q;
  assign nxt_o     = nxt_q;
  assign cnt_o     = cnt_q;
  assign cur_vld_o = cur_vld_q;
  assign nxt_vld_o = nxt_vld_q;

  assert_addr_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_wr_i && !active_i && !srst_i && !take) |=> (cur_q == $past(addr_wd_i)));
  assert_cnt_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == '0) && !cnt_wr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
#(
  parameter int          AW     = 32,
  parameter int          CW     = 24,
  parameter logic [3:0]  DEV_ID = 4'h9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          dev_irq_i,
  input  logic          err_i,
  input  logic          pack_we_i,
  input  logic [1:0]    pack_cnt_i,
  input  logic [1:0]    byte_off_i,
  input  logic          active_i,
  input  logic          cnt_dec_i,
  input  logic          nxt_take_i,
  output logic          irq_o,
  output logic          eng_rst_o,
  output logic          ena_o,
  output logic          dir_o,
  output logic          fast_o,
  output logic [AW-1:0] cur_addr_o
);
  ctl_t          wr_ctl, ctl;
  logic          csr_wr, addr_wr, cnt_wr, flush, srst;
  logic          tc, ep, serr, ip, tc_evt, cur_vld, nxt_vld;
  logic [1:0]    pack;
  logic [AW-1:0] cur, nxt;
  logic [CW-1:0] cnt;
  logic [31:0]   csr_rd;

  assign csr_wr  = we_i && (sel_i == SEL_CSR);
  assign addr_wr = we_i && (sel_i == SEL_ADDR) && !srst;
  assign cnt_wr  = we_i && (sel_i == SEL_CNT)  && !srst;
  assign flush   = csr_wr && wdata_i[P_FLUSH];

  always_comb begin
    wr_ctl.nxt_en  = wdata_i[P_NXTEN];
    wr_ctl.tc_mask = wdata_i[P_TCMSK];
    wr_ctl.fast    = wdata_i[P_FAST];
    wr_ctl.cnt_en  = wdata_i[P_CNTEN];
    wr_ctl.run     = wdata_i[P_RUN];
    wr_ctl.dir     = wdata_i[P_DIR];
    wr_ctl.ie      = wdata_i[P_IE];
  end

  dma_ctl_bits u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .csr_wr_i (csr_wr),
    .wr_ctl_i (wr_ctl),
    .wr_srst_i(wdata_i[P_SRST]),
    .ctl_o    (ctl),
    .srst_o   (srst)
  );

  dma_stat_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .flush_i   (flush),
    .tc_evt_i  (tc_evt),
    .err_i     (err_i),
    .pack_we_i (pack_we_i),
    .pack_cnt_i(pack_cnt_i),
    .tc_o      (tc),
    .ep_o      (ep),
    .serr_o    (serr),
    .pack_o    (pack)
  );

  dma_addr_cnt #(.AW(AW), .CW(CW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .addr_wr_i (addr_wr),
    .cnt_wr_i  (cnt_wr),
    .addr_wd_i (wdata_i[AW-1:0]),
    .cnt_wd_i  (wdata_i[CW-1:0]),
    .active_i  (active_i),
    .nxt_en_i  (ctl.nxt_en),
    .run_i     (ctl.run && ctl.cnt_en),
    .cnt_dec_i (cnt_dec_i),
    .nxt_take_i(nxt_take_i),
    .cur_o     (cur),
    .nxt_o     (nxt),
    .cnt_o     (cnt),
    .cur_vld_o (cur_vld),
    .nxt_vld_o (nxt_vld),
    .tc_evt_o  (tc_evt)
  );

  assign ip    = dev_irq_i || (tc && !ctl.tc_mask);
  assign irq_o = ctl.ie && (ip || ep);

  always_comb begin
    csr_rd                       = '0;
    csr_rd[P_ID+:4]              = DEV_ID;
    csr_rd[P_NXTV]               = nxt_vld;
    csr_rd[P_CURV]               = cur_vld;
    csr_rd[P_ACT]                = active_i;
    csr_rd[P_NXTEN]              = ctl.nxt_en;
    csr_rd[P_TCMSK]              = ctl.tc_mask;
    csr_rd[P_FAST]               = ctl.fast;
    csr_rd[P_TC]                 = tc;
    csr_rd[P_CNTEN]              = ctl.cnt_en;
    csr_rd[P_BOFF+:2]            = byte_off_i;
    csr_rd[P_RUN]                = ctl.run;
    csr_rd[P_DIR]                = ctl.dir;
    csr_rd[P_SRST]               = srst;
    csr_rd[P_SERR]               = serr;
    csr_rd[P_IE]                 = ctl.ie;
    csr_rd[P_PACK+:2]            = pack;
    csr_rd[P_EP]                 = ep;
    csr_rd[P_IP]                 = ip;
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_CSR:  rdata_o = csr_rd;
      SEL_ADDR: rdata_o[AW-1:0] = cur;
      SEL_CNT:  rdata_o[CW-1:0] = cnt;
      default:  rdata_o[AW-1:0] = nxt;
    endcase
  end

  assign eng_rst_o  = srst;
  assign ena_o      = ctl.run;
  assign dir_o      = ctl.dir;
  assign fast_o     = ctl.fast;
  assign cur_addr_o = cur;

  assert_irq_needs_ie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl.ie);
  assert_tc_raises_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && !ctl.tc_mask && ctl.ie) |-> irq_o);
  assert_fixed_fields_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_CSR) |-> ((rdata_o[31:28] == DEV_ID) && (rdata_o[19:16] == 4'h0)
                            && !rdata_o[P_FLUSH]));
endmodule

// File: tb/dma_csr_regs_test.sv
module dma_csr_regs_test;
  localparam logic [31:0] K_ID   = 32'h9000_0000;
  localparam logic [31:0] K_IE   = 32'h0000_0010;
  localparam logic [31:0] K_FL   = 32'h0000_0020;
  localparam logic [31:0] K_RS   = 32'h0000_0080;
  localparam logic [31:0] K_DIR  = 32'h0000_0100;
  localparam logic [31:0] K_RUN  = 32'h0000_0200;
  localparam logic [31:0] K_CEN  = 32'h0000_2000;
  localparam logic [31:0] K_FAST = 32'h0040_0000;
  localparam logic [31:0] K_MSK  = 32'h0080_0000;
  localparam logic [31:0] K_NXE  = 32'h0100_0000;
  localparam logic [31:0] K_JUNK = 32'hFE0F_DC4F;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [1:0]  sel_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        dev_irq_i = 1'b0, err_i = 1'b0, pack_we_i = 1'b0;
  logic [1:0]  pack_cnt_i = '0, byte_off_i = '0;
  logic        active_i = 1'b0, cnt_dec_i = 1'b0, nxt_take_i = 1'b0;
  logic        irq_o, eng_rst_o, ena_o, dir_o, fast_o;
  logic [15:0] cur_addr_o;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_csr_regs #(.AW(16), .CW(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .dev_irq_i(dev_irq_i), .err_i(err_i), .pack_we_i(pack_we_i),
    .pack_cnt_i(pack_cnt_i), .byte_off_i(byte_off_i), .active_i(active_i),
    .cnt_dec_i(cnt_dec_i), .nxt_take_i(nxt_take_i), .irq_o(irq_o),
    .eng_rst_o(eng_rst_o), .ena_o(ena_o), .dir_o(dir_o), .fast_o(fast_o),
    .cur_addr_o(cur_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); sel_i = s; we_i = 1'b1; wdata_i = d;
    @(negedge clk); we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    sel_i = s; #1; d = rdata_o;
  endtask

  task automatic dec_pulse;
    @(negedge clk); cnt_dec_i = 1'b1; @(negedge clk); cnt_dec_i = 1'b0;
  endtask

  task automatic err_pulse;
    @(negedge clk); err_i = 1'b1; @(negedge clk); err_i = 1'b0;
  endtask

  task automatic pack_load(input logic [1:0] v);
    @(negedge clk); pack_cnt_i = v; pack_we_i = 1'b1; @(negedge clk); pack_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    rd(0, r); chk("R1 reset value", r, K_ID);
    chk("R3 eng_rst after reset", {31'b0, eng_rst_o}, 32'h0);
    chk("R6 irq after reset", {31'b0, irq_o}, 32'h0);

    // R2: every control combination, junk in read-only fields
    for (int m = 0; m < 128; m++) begin
      logic [31:0] v;
      v = (m[0] ? K_IE : 0) | (m[1] ? K_DIR : 0) | (m[2] ? K_RUN : 0) | (m[3] ? K_CEN : 0)
        | (m[4] ? K_FAST : 0) | (m[5] ? K_MSK : 0) | (m[6] ? K_NXE : 0);
      wr(0, v | K_JUNK);
      rd(0, r); chk("R2 control readback", r, K_ID | v);
      chk("R2 engine outputs", {29'b0, ena_o, dir_o, fast_o}, {29'b0, v[9], v[8], v[22]});
    end
    wr(0, 0);

    // R10: write visible only after the edge
    @(negedge clk); sel_i = 0; we_i = 1'b1; wdata_i = K_IE; #1;
    chk("R10 before edge", rdata_o, K_ID);
    @(negedge clk); we_i = 1'b0; wdata_i = '0; #1;
    chk("R10 after edge", rdata_o, K_ID | K_IE);
    wr(0, 0);

    // R8: pass-through fields and pack count
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 2; a++) begin
        byte_off_i = 2'(b); active_i = a[0];
        rd(0, r); chk("R8 offset/active", r, K_ID | (32'(b) << 11) | (32'(a) << 25));
      end
    active_i = 1'b0; byte_off_i = '0;
    for (int p = 0; p < 4; p++) begin
      pack_load(2'(p));
      rd(0, r); chk("R8 pack count", r, K_ID | (32'(p) << 2));
    end
    wr(0, K_FL);
    rd(0, r); chk("R4 flush clears pack", r, K_ID);

    // R5: counter expiry for every load value
    for (int n = 1; n < 16; n++) begin
      logic [15:0] a0;
      a0 = 16'(n * 256);
      wr(0, K_RUN | K_CEN | K_FL);
      wr(2, 32'(n));
      wr(1, {16'b0, a0});
      repeat (n - 1) dec_pulse();
      rd(2, r); chk("R5 count before last", r, 32'd1);
      rd(0, r); chk("R5 no tc early", {31'b0, r[14]}, 32'h0);
      dec_pulse();
      rd(2, r); chk("R5 count zero", r, 32'd0);
      rd(0, r); chk("R5 tc set", {31'b0, r[14]}, 32'h1);
      rd(1, r); chk("R5 address advanced", r, {16'b0, a0 + 16'(n)});
      dec_pulse();
      rd(2, r); chk("R5 no wrap", r, 32'd0);
      rd(1, r); chk("R5 address stops", r, {16'b0, a0 + 16'(n)});
    end
    wr(0, K_RUN | K_FL);
    wr(2, 32'd5);
    dec_pulse();
    rd(2, r); chk("R5 count enable off", r, 32'd5);
    rd(0, r); chk("R5 no tc when disabled", {31'b0, r[14]}, 32'h0);

    // R6: interrupt truth table
    for (int c = 0; c < 32; c++) begin
      logic ie, dv, tcf, msk, epf, e_ip, e_irq;
      ie = c[0]; dv = c[1]; tcf = c[2]; msk = c[3]; epf = c[4];
      dev_irq_i = 1'b0;
      wr(0, K_RUN | K_CEN | K_FL);
      if (tcf) begin wr(2, 32'd1); dec_pulse(); end
      if (epf) err_pulse();
      wr(0, K_RUN | K_CEN | (ie ? K_IE : 0) | (msk ? K_MSK : 0));
      dev_irq_i = dv;
      e_ip  = dv | (tcf & ~msk);
      e_irq = ie & (e_ip | epf);
      rd(0, r);
      chk("R6 irq output", {31'b0, irq_o}, {31'b0, e_irq});
      chk("R6 R7 pending bits", {30'b0, r[1:0]}, {30'b0, epf, e_ip});
    end
    dev_irq_i = 1'b0;

    // R4: flush beats same-cycle error and terminal count
    wr(0, K_RUN | K_CEN | K_FL);
    wr(2, 32'd1);
    err_pulse();
    pack_load(2'd2);
    @(negedge clk); sel_i = 0; we_i = 1'b1; wdata_i = K_RUN | K_CEN | K_FL;
    err_i = 1'b1; cnt_dec_i = 1'b1;
    @(negedge clk); we_i = 1'b0; wdata_i = '0; err_i = 1'b0; cnt_dec_i = 1'b0;
    rd(0, r); chk("R4 flush wins", {27'b0, r[14], r[5], r[3:2], r[1]}, 32'h0);
    rd(2, r); chk("R4 counter still stepped", r, 32'd0);
    rd(0, r); chk("R7 slave error survives flush", {31'b0, r[6]}, 32'h1);

    // R9: address slots
    wr(0, 0);
    wr(1, 32'hA5A5);
    rd(1, r); chk("R9 idle load", r, 32'hA5A5);
    rd(0, r); chk("R9 current loaded flag", {31'b0, r[26]}, 32'h1);
    active_i = 1'b1;
    wr(1, 32'h1111);
    rd(1, r); chk("R9 busy write ignored", r, 32'hA5A5);
    rd(0, r); chk("R9 next flag clear", {31'b0, r[27]}, 32'h0);
    wr(0, K_NXE);
    wr(1, 32'h2222);
    rd(1, r); chk("R9 current kept", r, 32'hA5A5);
    rd(3, r); chk("R9 next slot loaded", r, 32'h2222);
    rd(0, r); chk("R9 next flag and active", {30'b0, r[27], r[25]}, 32'h3);
    @(negedge clk); nxt_take_i = 1'b1; @(negedge clk); nxt_take_i = 1'b0;
    rd(1, r); chk("R9 take moves next", r, 32'h2222);
    rd(0, r); chk("R9 take clears flag", {31'b0, r[27]}, 32'h0);
    chk("R9 address output", {16'b0, cur_addr_o}, 32'h2222);
    active_i = 1'b0;

    // R3: sticky soft reset
    wr(0, K_IE | K_RUN | K_CEN);
    err_pulse();
    wr(0, K_RS | K_IE | K_RUN);
    repeat (4) @(negedge clk);
    rd(0, r); chk("R3 soft reset clears state", r, K_ID | K_RS);
    chk("R3 eng_rst follows bit", {31'b0, eng_rst_o}, 32'h1);
    rd(1, r); chk("R3 address cleared", r, 32'h0);
    rd(3, r); chk("R3 next cleared", r, 32'h0);
    wr(1, 32'h3333);
    rd(1, r); chk("R3 address write ignored", r, 32'h0);
    wr(0, K_IE);
    rd(0, r); chk("R3 release ignores other bits", r, K_ID);
    chk("R3 eng_rst released", {31'b0, eng_rst_o}, 32'h0);
    wr(0, K_IE);
    rd(0, r); chk("R3 writable after release", r, K_ID | K_IE);
    wr(0, K_RS);
    @(negedge clk); rst_ni = 1'b0; #1;
    rd(0, r); chk("R3 power-on reset clears bit", r, K_ID);
    @(negedge clk); rst_ni = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule